// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of a 32-bit flash bus that is built from two 16-bit NOR devices placed side by side. A client asks it to erase one sector or to program one 32-bit word. The sequencer then issues the device command writes through a simple request/acknowledge memory-bus master port. It polls the status word until both devices signal ready, checks for errors, and always leaves both devices in read-array mode.

Each command byte is copied into both 16-bit lanes so that the two devices see the same command at the same time. A program request first reads the target word and is refused if any bit would have to change from 0 to 1. An erase request is refused at once if the protect flag of its sector is set. A per-operation cycle counter limits how long polling may last. Each request ends with a one-cycle done pulse and a result code.

Top module: `nor_cmd_seq`

## Requirements
- R1: Every command write carries its 8-bit code in bits 7:0 and again in bits 23:16, with bits 31:24 and 15:8 zero (0x20 is sent as 0x00200020). The program data word is the only write exempt from this.
- R2: An erase (op_i=1) of an unprotected sector writes 0x20 and then 0xD0 to addr_i, polls status, and then writes 0xFF.
- R3: A program (op_i=0) first reads addr_i. If (read & data_i) != data_i, it finishes with code 2 (not erased) and issues no write. Otherwise it writes 0x50, 0x40, data_i and 0x70 in that order, polls, and then writes 0xFF.
- R4: Polling continues until a status read has both bit 7 and bit 23 set. A status word with only one of the two lanes ready is treated as busy.
- R5: During a program poll, the error bits are bits 1, 3, 4 and 5 of each lane. The upper lane (bits 23:16) is used if any of its error bits is set; otherwise the lower lane is used. The result is ranked as follows: bit 1 gives code 2, then bit 4 gives code 3, then bit 3 gives code 4 (low programming voltage), and any other error bit gives code 3. The operation then writes 0xFF.
- R6: The poll timer restarts for each request and counts clock cycles while polling. When it reaches ERASE_LIMIT (erase) or PROG_LIMIT (program) before ready, the block writes 0xB0 and then 0xFF, and finishes with code 5.
- R7: Every request that issued any command ends with a 0xFF write to addr_i. All writes of a request go to addr_i.
- R8: An erase whose sector has prot_i[sect_i] set finishes with code 1 and performs no bus transaction at all.
- R9: While bus_req_o is high and bus_ack_i is low, bus_req_o, bus_we_o, bus_addr_o and bus_wdata_o hold their values.
- R10: done_o is high for exactly one cycle per request, with err_o valid in that cycle (0 = success). busy_o is low in the following cycle.
- R11: During an erase poll, error bits are ignored; only readiness or the timeout ends the poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start pulse, sampled while idle |
| op_i | input | 1 | 1 = sector erase, 0 = word program |
| addr_i | input | AW | Target address |
| data_i | input | 32 | Word to program |
| sect_i | input | $clog2(NSECT) | Sector index for the protect check |
| prot_i | input | NSECT | Per-sector protect flags |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 3 | Result code, valid with done_o |
| bus_req_o | output | 1 | Bus transaction request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | 32 | Bus write data |
| bus_ack_i | input | 1 | Bus transaction acknowledge |
| bus_rdata_i | input | 32 | Bus read data |

## Verification
The bench sweeps every combination of upper-lane and lower-lane error bits during a program poll. A decoder that looks at the lower lane first, or that ranks the bits in the wrong order, returns the wrong code. Status words with only one lane ready are used to catch a design that completes on one device and would read back a word that is still being written. Both timeouts are measured in cycles against their separate limits: a shared or unreset timer ends early or late, and a missing suspend write shows up in the logged command stream. Erase polls that carry error bits, and protected sectors that must leave the bus untouched, expose designs that decode errors during erase or issue commands before the protect check.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_PROT      = 3'd1,
    ERR_NOTERASED = 3'd2,
    ERR_PROG      = 3'd3,
    ERR_VLOW      = 3'd4,
    ERR_TMO       = 3'd5
  } err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PRERD, S_CLR, S_PSET, S_PDATA, S_RDST,
    S_ESET, S_ECONF, S_POLL, S_SUSP, S_RDARR, S_DONE
  } st_e;

  localparam logic [7:0] C_ESETUP = 8'h20;
  localparam logic [7:0] C_ECONF  = 8'hD0;
  localparam logic [7:0] C_CLRST  = 8'h50;
  localparam logic [7:0] C_PSETUP = 8'h40;
  localparam logic [7:0] C_RDST   = 8'h70;
  localparam logic [7:0] C_SUSP   = 8'hB0;
  localparam logic [7:0] C_RDARR  = 8'hFF;

  function automatic logic [31:0] dup_cmd(input logic [7:0] c);
    return {8'h00, c, 8'h00, c};
  endfunction
endpackage

// File: rtl/nfs_op_timer.sv
module nfs_op_timer #(
  parameter int unsigned ERASE_LIMIT = 2000,
  parameter int unsigned PROG_LIMIT  = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic erase_i,
  output logic expired_o
);
  localparam int unsigned MAXL = (ERASE_LIMIT > PROG_LIMIT) ? ERASE_LIMIT : PROG_LIMIT;
  localparam int unsigned CW   = $clog2(MAXL + 1);

  logic [CW-1:0] cnt_q, lim;

  assign lim = erase_i ? CW'(ERASE_LIMIT) : CW'(PROG_LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (run_i && cnt_q < lim) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q >= lim);

  p_cnt_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MAXL));
  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/nfs_stat_decode.sv
module nfs_stat_decode
  import nfs_pkg::*;
(
  input  logic [3:0] hi_i,   // lane bits {5,4,3,1}
  input  logic [3:0] lo_i,
  output logic       hit_o,
  output err_e       code_o
);
  logic [3:0] sel;

  always_comb begin
    sel    = (|hi_i) ? hi_i : lo_i;
    hit_o  = |sel;
    code_o = ERR_NONE;
    if (sel[0])      code_o = ERR_NOTERASED;
    else if (sel[2]) code_o = ERR_PROG;
    else if (sel[1]) code_o = ERR_VLOW;
    else if (sel[3]) code_o = ERR_PROG;
  end

  always_comb begin
    if (hit_o) p_code_set_r5: assert (code_o != ERR_NONE);
  end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nfs_pkg::*;
#(
  parameter int unsigned AW          = 24,
  parameter int unsigned NSECT       = 64,
  parameter int unsigned ERASE_LIMIT = 2000,
  parameter int unsigned PROG_LIMIT  = 300,
  localparam int unsigned SW         = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   data_i,
  input  logic [SW-1:0] sect_i,
  input  logic [NSECT-1:0] prot_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [2:0]    err_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [31:0]   bus_wdata_o,
  input  logic          bus_ack_i,
  input  logic [31:0]   bus_rdata_i
);
  st_e           st_q;
  logic          erase_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   data_q;
  err_e          err_q;
  logic          tmo, dec_hit, both_rdy;
  err_e          dec_code;

  nfs_op_timer #(.ERASE_LIMIT(ERASE_LIMIT), .PROG_LIMIT(PROG_LIMIT)) u_timer (
    .clk_i, .rst_ni,
    .clr_i    (st_q == S_IDLE),
    .run_i    (st_q == S_POLL),
    .erase_i  (erase_q),
    .expired_o(tmo)
  );

  nfs_stat_decode u_dec (
    .hi_i  ({bus_rdata_i[21:19], bus_rdata_i[17]}),
    .lo_i  ({bus_rdata_i[5:3],   bus_rdata_i[1]}),
    .hit_o (dec_hit),
    .code_o(dec_code)
  );

  assign both_rdy = bus_rdata_i[23] & bus_rdata_i[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      erase_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      err_q   <= ERR_NONE;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_i) begin
          erase_q <= op_i;
          addr_q  <= addr_i;
          data_q  <= data_i;
          err_q   <= ERR_NONE;
          if (op_i && prot_i[sect_i]) begin
            err_q <= ERR_PROT;
            st_q  <= S_DONE;
          end else begin
            st_q <= op_i ? S_ESET : S_PRERD;
          end
        end
        S_PRERD: if (bus_ack_i) begin
          if ((bus_rdata_i & data_q) != data_q) begin
            err_q <= ERR_NOTERASED;
            st_q  <= S_DONE;
          end else st_q <= S_CLR;
        end
        S_CLR:   if (bus_ack_i) st_q <= S_PSET;
        S_PSET:  if (bus_ack_i) st_q <= S_PDATA;
        S_PDATA: if (bus_ack_i) st_q <= S_RDST;
        S_RDST:  if (bus_ack_i) st_q <= S_POLL;
        S_ESET:  if (bus_ack_i) st_q <= S_ECONF;
        S_ECONF: if (bus_ack_i) st_q <= S_POLL;
        S_POLL: if (bus_ack_i) begin
          if (both_rdy) st_q <= S_RDARR;
          else if (tmo) begin
            err_q <= ERR_TMO;
            st_q  <= S_SUSP;
          end else if (!erase_q && dec_hit) begin
            err_q <= dec_code;
            st_q  <= S_RDARR;
          end
        end
        S_SUSP:  if (bus_ack_i) st_q <= S_RDARR;
        S_RDARR: if (bus_ack_i) st_q <= S_DONE;
        S_DONE:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req_o   = 1'b1;
    bus_we_o    = 1'b1;
    bus_wdata_o = '0;
    unique case (st_q)
      S_PRERD: bus_we_o = 1'b0;
      S_POLL:  bus_we_o = 1'b0;
      S_CLR:   bus_wdata_o = dup_cmd(C_CLRST);
      S_PSET:  bus_wdata_o = dup_cmd(C_PSETUP);
      S_PDATA: bus_wdata_o = data_q;
      S_RDST:  bus_wdata_o = dup_cmd(C_RDST);
      S_ESET:  bus_wdata_o = dup_cmd(C_ESETUP);
      S_ECONF: bus_wdata_o = dup_cmd(C_ECONF);
      S_SUSP:  bus_wdata_o = dup_cmd(C_SUSP);
      S_RDARR: bus_wdata_o = dup_cmd(C_RDARR);
      default: begin
        bus_req_o = 1'b0;
        bus_we_o  = 1'b0;
      end
    endcase
  end

  assign bus_addr_o = addr_q;
  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = (st_q == S_DONE);
  assign err_o      = err_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o)
                                && $stable(bus_we_o) && $stable(bus_wdata_o));
  p_cmd_dup_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o && st_q != S_PDATA |->
      bus_wdata_o[31:24] == 8'h00 && bus_wdata_o[15:8] == 8'h00
      && bus_wdata_o[7:0] == bus_wdata_o[23:16]);
  p_prot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == S_IDLE && req_i && op_i && prot_i[sect_i] |=>
      !bus_req_o && done_o && err_o == ERR_PROT);
  p_poll_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == S_POLL && bus_ack_i && !both_rdy && !tmo && (erase_q || !dec_hit)
      |=> st_q == S_POLL);
  p_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
endmodule

// File: tb/nor_cmd_seq_test.sv
module nor_cmd_seq_test;
  localparam int AW = 16, NS = 8, ELIM = 120, PLIM = 50;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic req = 0, op = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] data = '0;
  logic [2:0] sect = '0;
  logic [NS-1:0] prot = '0;
  logic busy, done, bus_req, bus_we;
  logic [2:0] err;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata;
  logic bus_ack = 0;
  logic [31:0] bus_rdata = '0;

  nor_cmd_seq #(.AW(AW), .NSECT(NS), .ERASE_LIMIT(ELIM), .PROG_LIMIT(PLIM)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .addr_i(addr), .data_i(data),
    .sect_i(sect), .prot_i(prot), .busy_o(busy), .done_o(done), .err_o(err),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata));

  // device model settings (driven by the stimulus process only)
  int lat = 0, rdy_after = 0;
  logic [31:0] arr_val = '1, busy_st = '0, fin_st = 32'h0080_0080;
  // model state
  int wcnt = 0, nw = 0, npoll = 0, nrd = 0, nbadaddr = 0;
  bit pre_done = 0;
  logic [31:0] wlog [16];

  always @(posedge clk) begin
    if (req && !busy) begin
      nw <= 0; npoll <= 0; nrd <= 0; pre_done <= 0; nbadaddr <= 0;
    end else if (bus_ack) bus_ack <= 0;
    else if (bus_req) begin
      if (wcnt >= lat) begin
        wcnt <= 0;
        bus_ack <= 1;
        if (bus_addr != addr) nbadaddr <= nbadaddr + 1;
        if (bus_we) begin
          if (nw < 16) wlog[nw] <= bus_wdata;
          nw <= nw + 1;
        end else begin
          nrd <= nrd + 1;
          if (!op && !pre_done) begin
            bus_rdata <= arr_val; pre_done <= 1;
          end else begin
            bus_rdata <= (npoll >= rdy_after) ? fin_st : busy_st;
            npoll <= npoll + 1;
          end
        end
      end else wcnt <= wcnt + 1;
    end
  end

  int nchk = 0, nerr = 0;
  logic [31:0] ew [8];
  int ne = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin nerr++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  function automatic logic [31:0] cw(input logic [7:0] c);
    return {8'h00, c, 8'h00, c};
  endfunction

  task automatic chk_writes(input string tag);
    chk(nw == ne, {tag, " write count"}, nw, ne);
    if (nw == ne)
      for (int i = 0; i < ne; i++) chk(wlog[i] == ew[i], {tag, " write word"}, wlog[i], ew[i]);
    chk(nbadaddr == 0, "R7 write address", nbadaddr, 0);
  endtask

  task automatic run_op(input bit er, input logic [AW-1:0] a, input logic [31:0] d,
                        input int s, output int cyc);
    @(negedge clk);
    op = er; addr = a; data = d; sect = 3'(s); req = 1;
    @(negedge clk);
    req = 0; cyc = 1;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(done, "R10 done reached", done, 1);
  endtask

  task automatic after_done();
    @(negedge clk);
    chk(!done && !busy, "R10 single done pulse", {done, busy}, 0);
  endtask

  function automatic int exp_code(input logic [7:0] u, input logic [7:0] l);
    logic [7:0] s;
    s = ((u & 8'h3A) != 0) ? u : l;
    s &= 8'h3A;
    if (s == 0) return 0;
    if (s[1]) return 2;
    if (s[4]) return 3;
    if (s[3]) return 4;
    return 3;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int cyc;
    logic [7:0] em [4];
    em[0] = 8'h02; em[1] = 8'h08; em[2] = 8'h10; em[3] = 8'h20;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_req, "reset idle state", {busy, done, bus_req}, 0);
    rst_n = 1;
    @(negedge clk);

    // R3 R4 R1: program success sweep
    for (int l = 0; l < 3; l++)
      for (int r = 0; r < 4; r++)
        for (int k = 0; k < 3; k++) begin
          logic [31:0] d;
          d = (k == 0) ? 32'h1234_5678 : (k == 1) ? 32'h0000_0000 : 32'hFFFF_FFFF;
          lat = l; rdy_after = r; arr_val = '1; busy_st = '0; fin_st = 32'h0080_0080;
          run_op(0, 16'(16'h0100 + 4*r), d, 0, cyc);
          chk(err == 0, "R3 program ok code", err, 0);
          ew[0] = cw(8'h50); ew[1] = cw(8'h40); ew[2] = d; ew[3] = cw(8'h70); ew[4] = cw(8'hFF); ne = 5;
          chk_writes("R3 R7 program sequence");
          chk(npoll == r + 1, "R4 poll count", npoll, r + 1);
          after_done();
        end

    // R3: not erased
    lat = 1; arr_val = 32'hFFFF_FEFF;
    run_op(0, 16'h0040, 32'h0000_0100, 0, cyc);
    chk(err == 2, "R3 not erased code", err, 2);
    chk(nw == 0, "R3 no writes when not erased", nw, 0);
    after_done();
    arr_val = 32'h00F0_0F00;
    run_op(0, 16'h0044, 32'h0000_0F00, 0, cyc);
    chk(err == 0, "R3 partial erase ok", err, 0);
    after_done();
    arr_val = '1;

    // R5: error decode sweep over lane combinations
    lat = 0; rdy_after = 2;
    for (int ui = 0; ui < 16; ui++)
      for (int li = 0; li < 16; li++) begin
        logic [7:0] u, lo;
        int ec;
        u = 0; lo = 0;
        for (int b = 0; b < 4; b++) begin
          if (ui[b]) u |= em[b];
          if (li[b]) lo |= em[b];
        end
        busy_st = {8'h00, u, 8'h00, lo};
        ec = exp_code(u, lo);
        run_op(0, 16'h0200, 32'hA5A5_0000, 0, cyc);
        chk(err == 3'(ec), "R5 error ranking", err, ec);
        ew[0] = cw(8'h50); ew[1] = cw(8'h40); ew[2] = 32'hA5A5_0000; ew[3] = cw(8'h70); ew[4] = cw(8'hFF); ne = 5;
        chk_writes("R5 R7 error path sequence");
        chk(npoll == ((ec == 0) ? 3 : 1), "R5 poll stop", npoll, (ec == 0) ? 3 : 1);
      end

    // R4: one lane ready is still busy
    busy_st = 32'h0000_0080; rdy_after = 3; lat = 1;
    run_op(0, 16'h0300, 32'h0, 0, cyc);
    chk(err == 0 && npoll == 4, "R4 lower lane only busy", npoll, 4);
    busy_st = 32'h0080_0000;
    run_op(0, 16'h0304, 32'h0, 0, cyc);
    chk(err == 0 && npoll == 4, "R4 upper lane only busy", npoll, 4);

    // R6: program timeout
    busy_st = 32'h0000_0080; rdy_after = 100000; lat = 0;
    run_op(0, 16'h0400, 32'h0F0F_0F0F, 0, cyc);
    chk(err == 5, "R6 program timeout code", err, 5);
    ew[0] = cw(8'h50); ew[1] = cw(8'h40); ew[2] = 32'h0F0F_0F0F; ew[3] = cw(8'h70);
    ew[4] = cw(8'hB0); ew[5] = cw(8'hFF); ne = 6;
    chk_writes("R6 program timeout sequence");
    chk(cyc >= PLIM && cyc <= PLIM + 40, "R6 program timeout window", cyc, PLIM);
    after_done();

    // R2 R8: erase sweep with protect mask
    rdy_after = 1; busy_st = '0; lat = 1; prot = 8'hA5;
    for (int s = 0; s < NS; s++) begin
      run_op(1, 16'(16'h1000 * s), 32'hDEAD_BEEF, s, cyc);
      if (prot[s]) begin
        chk(err == 1, "R8 protected code", err, 1);
        chk(nw == 0 && nrd == 0, "R8 no bus activity", nw + nrd, 0);
      end else begin
        chk(err == 0, "R2 erase ok code", err, 0);
        ew[0] = cw(8'h20); ew[1] = cw(8'hD0); ew[2] = cw(8'hFF); ne = 3;
        chk_writes("R2 R7 erase sequence");
        chk(npoll == 2, "R4 erase poll count", npoll, 2);
      end
      after_done();
    end
    prot = '0;

    // R11: erase ignores error bits
    busy_st = 32'h003A_003A; rdy_after = 3;
    run_op(1, 16'h2000, 32'h0, 2, cyc);
    chk(err == 0, "R11 erase ignores error bits", err, 0);
    chk(npoll == 4, "R11 erase keeps polling", npoll, 4);

    // R6: erase timeout
    busy_st = 32'h0080_0000; rdy_after = 100000; lat = 0;
    run_op(1, 16'h3000, 32'h0, 3, cyc);
    chk(err == 5, "R6 erase timeout code", err, 5);
    ew[0] = cw(8'h20); ew[1] = cw(8'hD0); ew[2] = cw(8'hB0); ew[3] = cw(8'hFF); ne = 4;
    chk_writes("R6 erase timeout sequence");
    chk(cyc >= ELIM && cyc <= ELIM + 30, "R6 erase timeout window", cyc, ELIM);
    after_done();

    // R6: timer restarts: short op right after a timeout
    rdy_after = 5; busy_st = '0;
    run_op(1, 16'h3000, 32'h0, 3, cyc);
    chk(err == 0, "R6 timer restart", err, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule